// File: doc/BRIEF.md
# Capture/Reload/Baud Timer

A 16-bit timer/counter with a two-byte capture/reload register and an 8-bit control register. It can run in one of three modes. In capture mode it counts freely and snapshots the count when an external trigger falls. In auto-reload mode it restarts from the reload value on overflow or on a trigger. In baud mode it also restarts from the reload value on overflow, and each overflow becomes a single-cycle tick for the receive side, the transmit side or both sides of a serial port.

The timer advances on a qualified tick input (`tick_en`) or, in counter mode, on falling edges of a count pin. The flag for a trigger event and the flag for an overflow stay set until software clears them. Either flag raises the interrupt request. When the timer is the baud source, both the overflow flag and the trigger pin are suppressed. Software reaches every register through a small byte-wide register port.

Top module: `crt_timer`

## Requirements
- R1: After reset, the control register, both count bytes and both reload bytes read 0x00, and `irq`, `rx_tick` and `tx_tick` are low.
- R2: In timer mode (run bit2 = 1, select bit1 = 0), the count rises by one on each clock edge where `tick_en` is high. With run = 0 the count holds.
- R3: In counter mode (bit1 = 1), the count rises once for each falling edge of `cnt_pin` (high in one sample, low in the next), and `tick_en` is ignored.
- R4: In capture mode (bit0 = 1, bits 5:4 = 0), the count wraps from 0xFFFF to 0x0000 and sets the overflow flag (bit7). With external enable (bit3) set, a falling edge on `trig_pin` copies the count into the reload bytes, leaves the count unchanged, and sets the external flag (bit6).
- R5: In reload mode (bit0 = 0), an overflow loads the count from the reload bytes and sets bit7. With bit3 set, a falling edge on `trig_pin` forces that load and sets bit6.
- R6: With bit3 clear, a falling edge on `trig_pin` changes neither the flags, the count nor the reload bytes.
- R7: When receive select (bit5) or transmit select (bit4) is 1, an overflow reloads the count but does not set bit7, and `trig_pin` has no effect.
- R8: In baud mode, each overflow yields exactly one one-cycle pulse on `rx_tick` if bit5 is set and on `tx_tick` if bit4 is set, in the cycle after the overflow.
- R9: Bits 7 and 6 stay set until software writes 0 to them. `irq` is high exactly while either of them is set.
- R10: Register addresses are 0 for control, 1/2 for count low/high and 3/4 for reload low/high. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` presents the addressed byte one cycle after `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| tick_en | input | 1 | Timer-mode count qualifier |
| cnt_pin | input | 1 | External count input, falling edge counts |
| trig_pin | input | 1 | External capture/reload trigger, falling edge |
| irq | output | 1 | Interrupt request, OR of the two flags |
| rx_tick | output | 1 | Receive baud tick |
| tx_tick | output | 1 | Transmit baud tick |

## Verification
A fault in the mode decode shows up at the next overflow or trigger. The count or reload bytes read back one cycle later carry the wrong value, or bit7 or bit6 appears when it should not. A corrupted count is visible on the register port in the cycle after the address is applied. An error on the baud path changes the number of ticks counted over a window of known overflows. A wrong edge-detector state adds or drops a count step for each pin pulse.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef struct packed {
    logic ovf;
    logic ext;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic run;
    logic cnt_sel;
    logic cap_sel;
  } crt_ctrl_t;

  localparam int CRT_BYTE = 8;
endpackage

// File: rtl/crt_fall_detect.sv
module crt_fall_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= pin_i[i];
    end
    assign fall_o[i] = prev_q[i] & ~pin_i[i];
  end
endmodule

// File: rtl/crt_ctrl_reg.sv
module crt_ctrl_reg
  import crt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_i,
  input  logic [7:0] wdata_i,
  input  logic      ovf_evt_i,
  input  logic      trig_fall_i,
  output crt_ctrl_t ctrl_o,
  output logic      baud_o,
  output logic      cap_evt_o,
  output logic      trig_rld_o
);
  crt_ctrl_t ctrl_q;
  logic      trig_ok;

  assign baud_o     = ctrl_q.rx_sel | ctrl_q.tx_sel;
  assign trig_ok    = trig_fall_i & ctrl_q.ext_en & ~baud_o;
  assign cap_evt_o  = trig_ok & ctrl_q.cap_sel;
  assign trig_rld_o = trig_ok & ~ctrl_q.cap_sel;
  assign ctrl_o     = ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_i) ctrl_q <= crt_ctrl_t'(wdata_i);
      ctrl_q.ovf <= (wr_i ? wdata_i[7] : ctrl_q.ovf) | (ovf_evt_i & ~baud_o);
      ctrl_q.ext <= (wr_i ? wdata_i[6] : ctrl_q.ext) | trig_ok;
    end
  end

  AST_NO_OVF_IN_BAUD: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q.ovf) |-> ($past(wr_i) || !$past(baud_o))); // R7
  AST_TRIG_QUIET_BAUD: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q.ext) |-> ($past(wr_i) || !$past(baud_o))); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_q.ovf) |-> $past(wr_i)); // R9
  AST_EXT_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_q.ext) |-> $past(wr_i)); // R9
endmodule

// File: rtl/crt_counter.sv
module crt_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             auto_rld_i,
  input  logic             trig_rld_i,
  input  logic             cap_evt_i,
  input  logic [WIDTH/8-1:0] cnt_wr_i,
  input  logic [WIDTH/8-1:0] rld_wr_i,
  input  logic [7:0]       wdata_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] rld_o,
  output logic             ovf_o
);
  localparam int NB = WIDTH / 8;

  logic [WIDTH-1:0] cnt_q, rld_q;

  assign ovf_o = inc_i & (&cnt_q);
  assign cnt_o = cnt_q;
  assign rld_o = rld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      if (trig_rld_i)               cnt_q <= rld_q;
      else if (ovf_o && auto_rld_i) cnt_q <= rld_q;
      else if (inc_i)               cnt_q <= cnt_q + 1'b1;
      for (int b = 0; b < NB; b++)
        if (cnt_wr_i[b]) cnt_q[b*8 +: 8] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q <= '0;
    end else if (cap_evt_i) begin
      rld_q <= cnt_q;
    end else begin
      for (int b = 0; b < NB; b++)
        if (rld_wr_i[b]) rld_q[b*8 +: 8] <= wdata_i;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !trig_rld_i && cnt_wr_i == '0) |=> $stable(cnt_q)); // R2
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc_i && (&cnt_q) && !auto_rld_i && !trig_rld_i && cnt_wr_i == '0) |=> cnt_q == '0); // R4
  AST_RELOAD_ON_OVF: assert property (@(posedge clk) disable iff (rst)
    (inc_i && (&cnt_q) && auto_rld_i && !trig_rld_i && cnt_wr_i == '0) |=> cnt_q == $past(rld_q)); // R5
  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (rst)
    cap_evt_i |=> rld_q == $past(cnt_q)); // R4
endmodule

// File: rtl/crt_tick_gen.sv
module crt_tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic ovf_i,
  input  logic rx_sel_i,
  input  logic tx_sel_i,
  output logic rx_tick_o,
  output logic tx_tick_o
);
  logic [1:0] sel;
  logic [1:0] tick_q;

  assign sel = {rx_sel_i, tx_sel_i};

  for (genvar i = 0; i < 2; i++) begin : g_tick
    always_ff @(posedge clk) begin
      if (rst) tick_q[i] <= 1'b0;
      else     tick_q[i] <= ovf_i & sel[i];
    end
  end

  assign rx_tick_o = tick_q[1];
  assign tx_tick_o = tick_q[0];

  AST_RX_TICK_SEL: assert property (@(posedge clk) disable iff (rst)
    rx_tick_o |-> $past(rx_sel_i)); // R8
  AST_TX_TICK_SEL: assert property (@(posedge clk) disable iff (rst)
    tx_tick_o |-> $past(tx_sel_i)); // R8
endmodule

// File: rtl/crt_timer.sv
module crt_timer
  import crt_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tick_en,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  output logic              irq,
  output logic              rx_tick,
  output logic              tx_tick
);
  localparam int NB = WIDTH / CRT_BYTE;

  crt_ctrl_t        ctrl;
  logic             baud, cap_evt, trig_rld, ovf, inc, ctrl_wr;
  logic [1:0]       fall;
  logic [NB-1:0]    cnt_wr, rld_wr;
  logic [WIDTH-1:0] cnt, rld;
  logic [7:0]       rd_sel;

  assign ctrl_wr = reg_wr && (reg_addr == '0);

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign cnt_wr[b] = reg_wr && (reg_addr == ADDR_W'(1 + b));
    assign rld_wr[b] = reg_wr && (reg_addr == ADDR_W'(1 + NB + b));
  end

  crt_fall_detect #(.N(2)) u_edges (
    .clk    (clk),
    .rst    (rst),
    .pin_i  ({trig_pin, cnt_pin}),
    .fall_o (fall)
  );

  assign inc = ctrl.run & (ctrl.cnt_sel ? fall[0] : tick_en);

  crt_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (ctrl_wr),
    .wdata_i     (reg_wdata),
    .ovf_evt_i   (ovf),
    .trig_fall_i (fall[1]),
    .ctrl_o      (ctrl),
    .baud_o      (baud),
    .cap_evt_o   (cap_evt),
    .trig_rld_o  (trig_rld)
  );

  crt_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .inc_i      (inc),
    .auto_rld_i (baud | ~ctrl.cap_sel),
    .trig_rld_i (trig_rld),
    .cap_evt_i  (cap_evt),
    .cnt_wr_i   (cnt_wr),
    .rld_wr_i   (rld_wr),
    .wdata_i    (reg_wdata),
    .cnt_o      (cnt),
    .rld_o      (rld),
    .ovf_o      (ovf)
  );

  crt_tick_gen u_ticks (
    .clk       (clk),
    .rst       (rst),
    .ovf_i     (ovf & baud),
    .rx_sel_i  (ctrl.rx_sel),
    .tx_sel_i  (ctrl.tx_sel),
    .rx_tick_o (rx_tick),
    .tx_tick_o (tx_tick)
  );

  assign irq = ctrl.ovf | ctrl.ext;

  always_comb begin
    rd_sel = '0;
    if (reg_addr == '0) rd_sel = ctrl;
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == ADDR_W'(1 + b))      rd_sel = cnt[b*8 +: 8];
      if (reg_addr == ADDR_W'(1 + NB + b)) rd_sel = rld[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_sel;
  end

  AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && !ovf && !fall[1]) |=> ($stable(irq))); // R9
  AST_TICK_ONLY_BAUD: assert property (@(posedge clk) disable iff (rst)
    (rx_tick || tx_tick) |-> $past(baud)); // R8
endmodule

// File: tb/crt_timer_test.sv
module crt_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tick_en = 1'b0;
  logic       cnt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic       irq, rx_tick, tx_tick;

  int checks = 0;
  int fails  = 0;
  int rx_n = 0;
  int tx_n = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  crt_timer uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
    .cnt_pin(cnt_pin), .trig_pin(trig_pin), .irq(irq),
    .rx_tick(rx_tick), .tx_tick(tx_tick)
  );

  // monitor: compares read data one cycle after address is presented
  always begin
    @(posedge clk);
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (reg_rdata !== it.exp) begin
        fails++;
        $display("FAIL %s: rdata actual %02h expected %02h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  // tick tally
  always begin
    @(posedge clk);
    #1;
    if (rx_tick) rx_n++;
    if (tx_tick) tx_n++;
  end

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input int act, input int e, input string tag);
    checks++;
    if (act != e) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, e);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic trigger();
    @(negedge clk);
    trig_pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    trig_pin = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    expect_rd(3'd0, 8'h00, "R1 ctrl");
    expect_rd(3'd1, 8'h00, "R1 cnt lo");
    expect_rd(3'd2, 8'h00, "R1 cnt hi");
    expect_rd(3'd3, 8'h00, "R1 rld lo");
    expect_rd(3'd4, 8'h00, "R1 rld hi");
    chk(irq, 0, "R1 irq");
    chk(rx_tick | tx_tick, 0, "R1 ticks");

    // R2 timer mode, R10 write/read
    wr(3'd1, 8'h10);
    expect_rd(3'd1, 8'h10, "R10 count write");
    wr(3'd0, 8'h04);
    ticks(5);
    expect_rd(3'd1, 8'h15, "R2 five ticks");
    wr(3'd0, 8'h00);
    ticks(3);
    expect_rd(3'd1, 8'h15, "R2 run off holds");

    // R3 counter mode, tick_en ignored
    wr(3'd0, 8'h06);
    tick_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); cnt_pin = 1'b0;
      @(negedge clk);
      @(negedge clk); cnt_pin = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
    wr(3'd0, 8'h00);
    expect_rd(3'd1, 8'h18, "R3 three edges");

    // R4 capture mode overflow
    wr(3'd1, 8'hFD);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h05);
    ticks(4);
    expect_rd(3'd0, 8'h85, "R4 ovf flag");
    expect_rd(3'd1, 8'h01, "R4 wrap lo");
    expect_rd(3'd2, 8'h00, "R4 wrap hi");
    chk(irq, 1, "R9 irq on ovf");
    repeat (5) @(negedge clk);
    expect_rd(3'd0, 8'h85, "R9 flag sticky");
    // R4 capture on trigger
    wr(3'd0, 8'h09);
    wr(3'd1, 8'h34);
    wr(3'd2, 8'h12);
    trigger();
    expect_rd(3'd3, 8'h34, "R4 capture lo");
    expect_rd(3'd4, 8'h12, "R4 capture hi");
    expect_rd(3'd1, 8'h34, "R4 count kept");
    expect_rd(3'd0, 8'h49, "R4 ext flag");
    chk(irq, 1, "R9 irq on ext");
    wr(3'd0, 8'h01);
    chk(irq, 0, "R9 cleared by write");

    // R6 trigger ignored without ext enable
    wr(3'd1, 8'h78);
    wr(3'd2, 8'h56);
    trigger();
    expect_rd(3'd3, 8'h34, "R6 rld lo kept");
    expect_rd(3'd4, 8'h12, "R6 rld hi kept");
    expect_rd(3'd1, 8'h78, "R6 count kept");
    expect_rd(3'd0, 8'h01, "R6 no flag");
    chk(irq, 0, "R6 irq low");

    // R5 reload mode
    wr(3'd3, 8'hF0);
    wr(3'd4, 8'hFF);
    wr(3'd1, 8'hFE);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h0C);
    ticks(3);
    expect_rd(3'd1, 8'hF1, "R5 reload on ovf lo");
    expect_rd(3'd2, 8'hFF, "R5 reload on ovf hi");
    expect_rd(3'd0, 8'h8C, "R5 ovf flag");
    wr(3'd0, 8'h08);
    trigger();
    expect_rd(3'd1, 8'hF0, "R5 trigger reload");
    expect_rd(3'd0, 8'h48, "R5 ext flag");
    wr(3'd0, 8'h00);

    // R7/R8 baud mode, receive select only
    wr(3'd3, 8'hFE);
    wr(3'd1, 8'hFE);
    wr(3'd0, 8'h2C);
    rx_n = 0; tx_n = 0;
    ticks(10);
    repeat (3) @(negedge clk);
    chk(rx_n, 5, "R8 rx ticks");
    chk(tx_n, 0, "R8 no tx ticks");
    expect_rd(3'd0, 8'h2C, "R7 no ovf flag");
    expect_rd(3'd1, 8'hFE, "R7 reload in baud");
    chk(irq, 0, "R7 irq low");
    wr(3'd0, 8'h28);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h01);
    trigger();
    expect_rd(3'd1, 8'h00, "R7 trig ignored lo");
    expect_rd(3'd2, 8'h01, "R7 trig ignored hi");
    expect_rd(3'd0, 8'h28, "R7 no ext flag");

    // R8 both selects
    wr(3'd1, 8'hFE);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h34);
    rx_n = 0; tx_n = 0;
    ticks(2);
    repeat (3) @(negedge clk);
    chk(rx_n, 1, "R8 both rx");
    chk(tx_n, 1, "R8 both tx");

    // R8 transmit select only
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hFE);
    wr(3'd0, 8'h14);
    rx_n = 0; tx_n = 0;
    ticks(2);
    repeat (3) @(negedge clk);
    chk(rx_n, 0, "R8 tx only rx");
    chk(tx_n, 1, "R8 tx only tx");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule